// File: doc/BRIEF.md
# DDR SDRAM Start-Up Command Sequencer

This block sits on the controller side of a DDR SDRAM interface and owns the command bus from reset until the memory is usable. After reset is released it raises the clock enable and holds the bus at no-operation for a stable period of 200 microseconds. The length of that period in cycles comes from a clock-frequency parameter. It then closes every bank with a precharge-all and writes the extended mode register and then the base mode register, with the DLL reset bit forced on in the base register. Next it issues a programmable number of auto-refresh commands, two by default, and waits a further fixed number of cycles. Only then does it flag that initialization is complete.

The values written to the two mode registers come from input ports, so the surrounding controller chooses burst length, latency and DLL options. Every command is followed by its own minimum gap before the next command: precharge time, mode-register time, refresh cycle time and the final settle period. Each gap is a parameter counted in clock cycles. Once the done flag rises the sequencer leaves the bus at no-operation. It keeps that state until the next reset, which restarts the whole sequence at any point.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_n is low, cke is 0, the bus is deselected (cs_n, ras_n, cas_n, we_n all 1), ba and addr are 0 and init_done is 0.
- R2: From the first rising edge with rst_n high, cke is 1 and remains 1. The bus then shows no-operation (cs_n=0, ras_n=cas_n=we_n=1, ba=0, addr=0) for exactly CLK_MHZ*STABLE_US cycles.
- R3: The next cycle carries a precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, addr bit 10 set and every other addr bit 0, ba=0.
- R4: Exactly T_RP cycles after the precharge-all, the extended mode register is written: all four command pins 0, ba=2'b01 (ba[0]=1, ba[1]=0), addr equal to ext_mode_val.
- R5: Exactly T_MRD cycles after that, the base mode register is written: all four command pins 0, ba=2'b00, addr equal to mode_val with addr bit 8 (DLL reset) forced to 1.
- R6: Exactly T_MRD cycles after the base register write, the first auto-refresh appears (cs_n=0, ras_n=0, cas_n=0, we_n=1, ba=0, addr=0). REF_COUNT refreshes are issued in total, each T_RFC cycles after the previous one.
- R7: Every cycle between two commands of the sequence is a no-operation with ba=0 and addr=0. No read, write or burst-terminate encoding ever appears.
- R8: init_done rises exactly T_RFC+FINAL_WAIT cycles after the last auto-refresh. From then on it stays 1 and the bus stays at no-operation with cke=1 until the next reset.
- R9: Asserting rst_n in the middle of the sequence returns all outputs to the R1 state at once. Releasing it restarts the sequence from the stable period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_val | input | ADDR_W | Value written into the base mode register (bit 8 forced high) |
| ext_mode_val | input | ADDR_W | Value written into the extended mode register |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe command pin |
| cas_n | output | 1 | Column strobe command pin |
| we_n | output | 1 | Write enable command pin |
| ba | output | BA_W | Bank address bits |
| addr | output | ADDR_W | Address / opcode bits |
| init_done | output | 1 | High once the sequence has finished, until reset |

## Verification
All outputs are registered, so a decision taken at one rising edge appears on the pins from that edge onward. The precharge-all is due at the (CLK_MHZ*STABLE_US+1)-th edge after reset release. Each later command is due exactly its gap parameter edges after the one before. init_done is due T_RFC+FINAL_WAIT edges after the last refresh. The bench builds a queue holding one expected bus word per cycle from these counts. It pops one entry per clock and compares it on the falling edge, so every pin is checked on every cycle, including the no-operation gaps, and an off-by-one in any gap is seen. Reset is checked in the cycles it is held, and once more 1 time unit after a mid-sequence assertion.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PREA,
        CMD_LMR,
        CMD_REF
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        STEP_PREA,
        STEP_EMR,
        STEP_MR,
        STEP_REF,
        STEP_FINAL,
        STEP_READY
    } seq_step_e;

    localparam int          AP_BIT        = 10;
    localparam int          DLL_RESET_BIT = 8;
    localparam logic [1:0]  BA_BASE_MR    = 2'b00;
    localparam logic [1:0]  BA_EXT_MR     = 2'b01;

endpackage

// File: rtl/ddr_cmd_encode.sv
module ddr_cmd_encode
    import ddr_init_pkg::*;
(
    input  bus_cmd_e cmd,
    output logic     cs_n,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n
);
    always_comb begin
        {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        case (cmd)
            CMD_NOP:  {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            CMD_PREA: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            CMD_LMR:  {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            CMD_REF:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            default:  {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
    end
endmodule

// File: rtl/init_wait_ctr.sv
module init_wait_ctr #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int BA_W       = 2,
    parameter int CLK_MHZ    = 50,
    parameter int STABLE_US  = 200,
    parameter int T_RP       = 2,
    parameter int T_MRD      = 2,
    parameter int T_RFC      = 5,
    parameter int REF_COUNT  = 2,
    parameter int FINAL_WAIT = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_val,
    input  logic [ADDR_W-1:0] ext_mode_val,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int MAX_A      = (STABLE_CYC > FINAL_WAIT) ? STABLE_CYC : FINAL_WAIT;
    localparam int MAX_B      = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_C      = (MAX_B > T_RFC) ? MAX_B : T_RFC;
    localparam int MAX_WAIT   = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W      = $clog2(MAX_WAIT + 1);
    localparam int REF_W      = $clog2(REF_COUNT + 1);

    typedef struct packed {
        seq_state_e        state;
        seq_step_e         step;
        logic [REF_W-1:0]  refs;
        logic              cke;
        bus_cmd_e          cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        state: ST_BOOT,
        step:  STEP_PREA,
        refs:  '0,
        cke:   1'b0,
        cmd:   CMD_DESEL,
        ba:    '0,
        addr:  '0,
        done:  1'b0
    };

    seq_t             s_d, s_q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             wait_over;

    init_wait_ctr #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (wait_over)
    );

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.ba   = '0;
        s_d.addr = '0;
        ld       = 1'b0;
        ld_val   = '0;
        case (s_q.state)
            ST_BOOT: begin
                s_d.cke   = 1'b1;
                s_d.state = ST_WAIT;
                s_d.step  = STEP_PREA;
                ld        = 1'b1;
                ld_val    = CNT_W'(STABLE_CYC - 1);
            end
            ST_WAIT: begin
                if (wait_over) begin
                    case (s_q.step)
                        STEP_PREA: begin
                            s_d.cmd          = CMD_PREA;
                            s_d.addr[AP_BIT] = 1'b1;
                            s_d.step         = STEP_EMR;
                            ld               = 1'b1;
                            ld_val           = CNT_W'(T_RP - 1);
                        end
                        STEP_EMR: begin
                            s_d.cmd  = CMD_LMR;
                            s_d.ba   = BA_W'(BA_EXT_MR);
                            s_d.addr = ext_mode_val;
                            s_d.step = STEP_MR;
                            ld       = 1'b1;
                            ld_val   = CNT_W'(T_MRD - 1);
                        end
                        STEP_MR: begin
                            s_d.cmd                 = CMD_LMR;
                            s_d.ba                  = BA_W'(BA_BASE_MR);
                            s_d.addr                = mode_val;
                            s_d.addr[DLL_RESET_BIT] = 1'b1;
                            s_d.step                = STEP_REF;
                            ld                      = 1'b1;
                            ld_val                  = CNT_W'(T_MRD - 1);
                        end
                        STEP_REF: begin
                            s_d.cmd  = CMD_REF;
                            s_d.refs = s_q.refs + 1'b1;
                            s_d.step = (s_q.refs == REF_W'(REF_COUNT - 1)) ? STEP_FINAL : STEP_REF;
                            ld       = 1'b1;
                            ld_val   = CNT_W'(T_RFC - 1);
                        end
                        STEP_FINAL: begin
                            s_d.step = STEP_READY;
                            ld       = 1'b1;
                            ld_val   = CNT_W'(FINAL_WAIT - 1);
                        end
                        default: begin
                            s_d.state = ST_DONE;
                            s_d.done  = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                s_d.done = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RESET;
        else        s_q <= s_d;
    end

    ddr_cmd_encode u_enc (
        .cmd   (s_q.cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    assign cke       = s_q.cke;
    assign ba        = s_q.ba;
    assign addr      = s_q.addr;
    assign init_done = s_q.done;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);
    // R1: quiet bus while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!cke && cs_n && ras_n && cas_n && we_n && !init_done)
                else $error("reset state violated");
        end
    end

    // R2: clock enable never drops once raised
    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R3: precharge always targets all banks
    a_r3_prea_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && !we_n) |-> (addr[10] && ba == '0));

    // R5: base mode register write carries the DLL reset bit
    a_r5_mr_dll_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n && ba == '0) |-> addr[8]);

    // R6: refresh carries no bank or address
    a_r6_ref_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && we_n) |-> (ba == '0 && addr == '0));

    // R7: no read, write or burst-terminate encoding
    a_r7_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !(ras_n && (!cas_n || !we_n)));

    // R8: done is sticky and the bus idles behind it
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cke && !cs_n && ras_n && cas_n && we_n));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;
    localparam int AW    = 13;
    localparam int MHZ   = 50;
    localparam int US    = 200;
    localparam int TRP   = 2;
    localparam int TMRD  = 2;
    localparam int TRFC  = 5;
    localparam int NREF  = 2;
    localparam int FWAIT = 200;
    localparam int SCYC  = MHZ * US;
    localparam int VW    = 8 + AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mode_val = '0;
    logic [AW-1:0] ext_val = '0;
    logic          cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [1:0]    ba;
    logic [AW-1:0] addr;

    int total = 0;
    int bad   = 0;

    logic [VW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;

    ddr_init_seq #(
        .ADDR_W(AW), .BA_W(2), .CLK_MHZ(MHZ), .STABLE_US(US), .T_RP(TRP),
        .T_MRD(TMRD), .T_RFC(TRFC), .REF_COUNT(NREF), .FINAL_WAIT(FWAIT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_val(mode_val), .ext_mode_val(ext_val),
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .init_done(init_done)
    );

    function automatic logic [VW-1:0] word(logic k, logic [3:0] c, logic [1:0] b,
                                           logic [AW-1:0] a, logic d);
        return {k, c, b, a, d};
    endfunction

    task automatic check(string tag, logic [VW-1:0] e);
        logic [VW-1:0] act;
        act = {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done};
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, e);
        end
    endtask

    task automatic push(int n, logic [VW-1:0] v, string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic build(logic [AW-1:0] mv, logic [AW-1:0] ev);
        logic [VW-1:0] nop;
        nop = word(1'b1, 4'b0111, 2'b00, '0, 1'b0);
        exp_q.delete();
        tag_q.delete();
        push(SCYC, nop, "R2 stable nop");
        push(1, word(1'b1, 4'b0010, 2'b00, AW'(13'h0400), 1'b0), "R3 precharge-all");
        push(TRP - 1, nop, "R7 gap after precharge");
        push(1, word(1'b1, 4'b0000, 2'b01, ev, 1'b0), "R4 ext mode write");
        push(TMRD - 1, nop, "R7 gap after ext mode");
        push(1, word(1'b1, 4'b0000, 2'b00, mv | AW'(13'h0100), 1'b0), "R5 base mode write");
        push(TMRD - 1, nop, "R7 gap after base mode");
        for (int r = 0; r < NREF; r++) begin
            push(1, word(1'b1, 4'b0001, 2'b00, '0, 1'b0), "R6 auto-refresh");
            push(TRFC - 1, nop, "R7 gap after refresh");
        end
        push(FWAIT, nop, "R8 final wait");
        push(64, word(1'b1, 4'b0111, 2'b00, '0, 1'b1), "R8 done held");
    endtask

    task automatic run(logic [AW-1:0] mv, logic [AW-1:0] ev, int stop_at);
        logic [VW-1:0] rst_word;
        rst_word = word(1'b0, 4'b1111, 2'b00, '0, 1'b0);
        mode_val = mv;
        ext_val  = ev;
        build(mv, ev);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset state", rst_word);
        end
        rst_n = 1'b1;
        for (int i = 0; i < exp_q.size(); i++) begin
            if (stop_at > 0 && i == stop_at) break;
            @(negedge clk);
            check(tag_q[i], exp_q[i]);
        end
        if (stop_at > 0) begin
            rst_n = 1'b0;
            #1;
            check("R9 mid-sequence reset", rst_word);
            @(negedge clk);
            check("R9 reset held", rst_word);
        end
    endtask

    initial begin
        #(64'd200000 * 20);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run(13'h0032, 13'h0000, 0);
        run(13'h0123, 13'h0002, 0);
        run(13'h1eff, 13'h1fff, SCYC / 2);
        run(13'h0061, 13'h0001, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule